// File: doc/BRIEF.md
# Brown-out Reset Release Sequencer

This block decides when the internal reset of a device may be released after a power-on, a return from power-down or a brown-out. A brown-out (supply below threshold) or a power-on event puts the block into a reset-asserted state. From there it walks through a regulator settling delay (power-on only) and a combined wait phase. In the wait phase, three things run at the same time: an oscillator start-up count, a PLL lock wait and a power-up timer. The reset is released only when all of the required conditions are met.

Every delay is counted in reference-clock ticks, except the oscillator start-up count, which counts oscillator-ready pulses. The clock source is decoded from a 3-bit source-select field and a 2-bit primary-mode field. When the programmed power-up period is zero and a crystal source is selected, a fixed fail-safe delay takes its place. A sticky flag records brown-outs until software clears it.

Top module: `bor_release_seq`

## Requirements
- R1: While `brownout_i` is high at a rising edge, the next edge leaves `sys_rst_o`=1, `clk_hold_o`=1, `exec_en_o`=0 and `bor_flag_o`=1. Brown-out is acted on in every phase, including after release.
- R2: A brown-out or power-on event during any wait phase restarts the sequence. The timing then counts again from the first edge at which both event inputs are low.
- R3: Counting that first quiet edge as edge 1, `sys_rst_o` falls on edge N = 1 + P + W. P = REG_TICKS if a power-on event (or `rst_n`) started a sequence whose regulator delay has not yet completed, and P = 0 otherwise. W is the wait-phase length. `exec_en_o` stays 0 throughout the regulator delay.
- R4: With a nonzero `pwrt_period_i` = T, the timer limit is L = T. With every clock-source condition already met, W = max(1, L).
- R5: When `pwrt_period_i` = 0, L = FSCM_TICKS if a crystal source is selected, and L = 0 otherwise.
- R6: A source is a crystal when `osc_sel_i`=3'b100, or when `osc_sel_i` is 3'b010 or 3'b011 and `pri_mode_i` is 2'b01 or 2'b10. For a crystal, the clock stays held until OST_EDGES pulses of `osc_tick_i` have been counted in the wait phase. With a pulse every cycle, W = max(1, L, OST_EDGES+1).
- R7: When `osc_sel_i` is 3'b001 or 3'b011, neither the clock hold nor the reset is released while `pll_locked_i` is 0. They fall on the first edge at which it reads 1 (timer already done). For any other source, `pll_locked_i` is ignored.
- R8: `clk_hold_o` falls on the first wait-phase edge at which the clock source is ready, which can be before reset release. That edge is 1 + P + C, where C = OST_EDGES+1 for a crystal with a pulse every cycle, and C = 1 otherwise.
- R9: `exec_en_o` rises on the same edge that `sys_rst_o` falls, and only while `clk_hold_o` is 0.
- R10: `bor_flag_o` stays set until `status_clr_i` is sampled high, which clears it on the next edge. If a brown-out is sampled in the same cycle as the clear, the flag stays set. A power-on event alone does not set it.
- R11: Once released, the reset stays released until a new event.
- R12: An active-low `rst_n` sets `sys_rst_o`=1, `clk_hold_o`=1, `exec_en_o`=0 and `bor_flag_o`=0, and then acts like a power-on event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| brownout_i | input | 1 | Supply-below-threshold flag from the comparator |
| por_i | input | 1 | Power-on or resume-from-power-down event |
| osc_sel_i | input | 3 | Clock source select field |
| pri_mode_i | input | 2 | Primary oscillator mode field |
| osc_tick_i | input | 1 | One pulse per oscillator-ready edge |
| pll_locked_i | input | 1 | PLL lock indicator |
| pwrt_period_i | input | PWRT_W | Power-up timer period in reference ticks |
| status_clr_i | input | 1 | Software clear of the brown-out flag |
| sys_rst_o | output | 1 | Internal reset, high while held |
| clk_hold_o | output | 1 | System clock gate hold |
| exec_en_o | output | 1 | Code execution enable |
| bor_flag_o | output | 1 | Sticky brown-out status |

## Verification
The bench sweeps every source-select and mode code against every power-up period of a small configuration, with power-on and brown-out starts mixed in. For each combination it compares the release edge and the clock-hold edge against the formulas above. A wrong crystal decode or a missing fail-safe substitution shows up as a release that is early or late by a whole delay. A hold that ignored the PLL or the oscillator count would release while the bench keeps lock low or withholds ticks. An event inside a wait that failed to restart the counters, or that lost a pending regulator delay, would release too soon. The bench also drives a flag clear in the same cycle as a brown-out, which a design that favoured the clear would get wrong.

// File: rtl/bor_seq_pkg.sv
package bor_seq_pkg;

  typedef enum logic [1:0] {
    ST_RESET   = 2'd0,
    ST_REGWAIT = 2'd1,
    ST_CLKWAIT = 2'd2,
    ST_RUN     = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic xtal;
    logic pll;
  } clk_src_t;

  // Clock-source decode: crystal (needs start-up count) and PLL usage.
  function automatic clk_src_t decode_src(input logic [2:0] sel,
                                          input logic [1:0] mode);
    clk_src_t s;
    logic     pri_xtal;
    pri_xtal = (mode == 2'b01) || (mode == 2'b10);
    s.pll    = (sel == 3'b001) || (sel == 3'b011);
    s.xtal   = (sel == 3'b100) || (((sel == 3'b010) || (sel == 3'b011)) && pri_xtal);
    return s;
  endfunction

  // A phase of limit L occupies max(1, L) cycles: done when cnt+1 >= L.
  function automatic logic reached(input logic [31:0] cnt, input logic [31:0] limit);
    return (cnt + 32'd1) >= limit;
  endfunction

  // Timer limit selection including the fail-safe substitute.
  function automatic logic [31:0] timer_limit(input logic [31:0] period,
                                              input logic        xtal,
                                              input logic [31:0] failsafe);
    if (period != 32'd0) return period;
    if (xtal)            return failsafe;
    return 32'd0;
  endfunction

endpackage

// File: rtl/bor_src_decode.sv
module bor_src_decode
  import bor_seq_pkg::*;
(
  input  logic [2:0] osc_sel,
  input  logic [1:0] pri_mode,
  output logic       is_xtal,
  output logic       uses_pll
);
  clk_src_t src;
  always_comb begin
    src      = decode_src(osc_sel, pri_mode);
    is_xtal  = src.xtal;
    uses_pll = src.pll;
  end
endmodule

// File: rtl/bor_sat_counter.sv
module bor_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = '1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clr)                   cnt <= '0;
    else if (inc && (cnt != CMAX))  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bor_seq_fsm.sv
module bor_seq_fsm
  import bor_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_bor,
  input  logic       evt_por,
  input  logic       reg_done,
  input  logic       tmr_done,
  input  logic       clk_ready,
  output seq_state_t state,
  output logic       state_chg,
  output logic       sys_rst_q,
  output logic       clk_hold_q,
  output logic       exec_en_q
);
  seq_state_t nxt;
  logic       need_reg;
  logic       restart;

  assign restart = evt_bor || evt_por;

  always_comb begin
    nxt = state;
    if (restart) begin
      nxt = ST_RESET;
    end else begin
      case (state)
        ST_RESET:   nxt = need_reg ? ST_REGWAIT : ST_CLKWAIT;
        ST_REGWAIT: if (reg_done) nxt = ST_CLKWAIT;
        ST_CLKWAIT: if (tmr_done && clk_ready) nxt = ST_RUN;
        default:    nxt = ST_RUN;
      endcase
    end
  end

  assign state_chg = (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RESET;
      need_reg   <= 1'b1;
      sys_rst_q  <= 1'b1;
      clk_hold_q <= 1'b1;
      exec_en_q  <= 1'b0;
    end else begin
      state <= nxt;
      if (evt_por)
        need_reg <= 1'b1;
      else if ((state == ST_REGWAIT) && (nxt == ST_CLKWAIT))
        need_reg <= 1'b0;
      sys_rst_q  <= (nxt != ST_RUN);
      exec_en_q  <= (nxt == ST_RUN);
      clk_hold_q <= !((nxt == ST_RUN) ||
                      ((state == ST_CLKWAIT) && clk_ready && !restart));
    end
  end
endmodule

// File: rtl/bor_release_seq.sv
module bor_release_seq
  import bor_seq_pkg::*;
#(
  parameter int PWRT_W     = 8,
  parameter int OST_EDGES  = 1024,
  parameter int FSCM_TICKS = 100,
  parameter int REG_TICKS  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brownout_i,
  input  logic              por_i,
  input  logic [2:0]        osc_sel_i,
  input  logic [1:0]        pri_mode_i,
  input  logic              osc_tick_i,
  input  logic              pll_locked_i,
  input  logic [PWRT_W-1:0] pwrt_period_i,
  input  logic              status_clr_i,
  output logic              sys_rst_o,
  output logic              clk_hold_o,
  output logic              exec_en_o,
  output logic              bor_flag_o
);
  localparam int PWRT_MAX = (1 << PWRT_W) - 1;
  localparam int DLY_MAX0 = (PWRT_MAX > FSCM_TICKS) ? PWRT_MAX : FSCM_TICKS;
  localparam int DLY_MAX  = (DLY_MAX0 > REG_TICKS) ? DLY_MAX0 : REG_TICKS;
  localparam int DLY_W    = $clog2(DLY_MAX + 2);
  localparam int OST_W    = $clog2(OST_EDGES + 2);

  seq_state_t       state;
  logic             state_chg;
  logic             xtal_src;
  logic             pll_used;
  logic [DLY_W-1:0] dly_cnt;
  logic [OST_W-1:0] ost_cnt;
  logic [31:0]      tmr_lim;
  logic             in_clkwait;
  logic             ost_done;
  logic             clk_ready;
  logic             tmr_done;
  logic             reg_done;
  logic             dly_inc;
  logic             ost_inc;

  bor_src_decode u_dec (
    .osc_sel  (osc_sel_i),
    .pri_mode (pri_mode_i),
    .is_xtal  (xtal_src),
    .uses_pll (pll_used)
  );

  assign in_clkwait = (state == ST_CLKWAIT);
  assign dly_inc    = (state == ST_REGWAIT) || in_clkwait;
  assign ost_done   = (32'(ost_cnt) >= 32'(OST_EDGES));
  assign ost_inc    = in_clkwait && xtal_src && osc_tick_i && !ost_done;
  assign clk_ready  = (!xtal_src || ost_done) && (!pll_used || pll_locked_i);
  assign tmr_lim    = timer_limit(32'(pwrt_period_i), xtal_src, 32'(FSCM_TICKS));
  assign tmr_done   = reached(32'(dly_cnt), tmr_lim);
  assign reg_done   = reached(32'(dly_cnt), 32'(REG_TICKS));

  bor_sat_counter #(.W(DLY_W)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_chg),
    .inc   (dly_inc),
    .cnt   (dly_cnt)
  );

  bor_sat_counter #(.W(OST_W)) u_ost (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_clkwait),
    .inc   (ost_inc),
    .cnt   (ost_cnt)
  );

  bor_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_bor    (brownout_i),
    .evt_por    (por_i),
    .reg_done   (reg_done),
    .tmr_done   (tmr_done),
    .clk_ready  (clk_ready),
    .state      (state),
    .state_chg  (state_chg),
    .sys_rst_q  (sys_rst_o),
    .clk_hold_q (clk_hold_o),
    .exec_en_q  (exec_en_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            bor_flag_o <= 1'b0;
    else if (brownout_i)   bor_flag_o <= 1'b1;
    else if (status_clr_i) bor_flag_o <= 1'b0;
  end
endmodule

// File: rtl/bor_release_seq_chk.sv
module bor_release_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic brownout_i,
  input logic por_i,
  input logic pll_locked_i,
  input logic status_clr_i,
  input logic pll_used,
  input logic sys_rst_o,
  input logic clk_hold_o,
  input logic exec_en_o,
  input logic bor_flag_o
);
  a_r1_bor_resets: assert property (@(posedge clk) disable iff (!rst_n)
    brownout_i |=> (sys_rst_o && clk_hold_o && !exec_en_o && bor_flag_o));

  a_r2_por_resets: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (sys_rst_o && !exec_en_o));

  a_r7_pll_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> (!$past(pll_used) || $past(pll_locked_i)));

  a_r9_exec_clean: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en_o |-> (!sys_rst_o && !clk_hold_o));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr_i && !brownout_i) |=> !bor_flag_o);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_flag_o && !status_clr_i) |=> bor_flag_o);

  a_r11_stays_run: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst_o && !brownout_i && !por_i) |=> !sys_rst_o);
endmodule

bind bor_release_seq bor_release_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .brownout_i   (brownout_i),
  .por_i        (por_i),
  .pll_locked_i (pll_locked_i),
  .status_clr_i (status_clr_i),
  .pll_used     (pll_used),
  .sys_rst_o    (sys_rst_o),
  .clk_hold_o   (clk_hold_o),
  .exec_en_o    (exec_en_o),
  .bor_flag_o   (bor_flag_o)
);

// File: tb/test_bor_release_seq.sv
`timescale 1ns/1ps
module test_bor_release_seq;
  localparam int E  = 8;
  localparam int F  = 12;
  localparam int R  = 5;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          brownout_i = 1'b0;
  logic          por_i = 1'b0;
  logic [2:0]    osc_sel_i = 3'd0;
  logic [1:0]    pri_mode_i = 2'd0;
  logic          osc_tick_i = 1'b1;
  logic          pll_locked_i = 1'b1;
  logic [PW-1:0] pwrt_period_i = 4'd3;
  logic          status_clr_i = 1'b0;
  logic          sys_rst_o, clk_hold_o, exec_en_o, bor_flag_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  bor_release_seq #(.PWRT_W(PW), .OST_EDGES(E), .FSCM_TICKS(F), .REG_TICKS(R)) i_bor_release_seq (
    .clk(clk), .rst_n(rst_n), .brownout_i(brownout_i), .por_i(por_i),
    .osc_sel_i(osc_sel_i), .pri_mode_i(pri_mode_i), .osc_tick_i(osc_tick_i),
    .pll_locked_i(pll_locked_i), .pwrt_period_i(pwrt_period_i),
    .status_clr_i(status_clr_i), .sys_rst_o(sys_rst_o), .clk_hold_o(clk_hold_o),
    .exec_en_o(exec_en_o), .bor_flag_o(bor_flag_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit is_xtal(input int sel, input int mode);
    case (sel)
      4:       return 1'b1;
      2, 3:    return (mode == 1) || (mode == 2);
      default: return 1'b0;
    endcase
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  function automatic int exp_rel(input int sel, input int mode, input int pw, input bit por);
    bit xt;
    int lim;
    xt  = is_xtal(sel, mode);
    lim = (pw != 0) ? pw : (xt ? F : 0);
    return 1 + (por ? R : 0) + max3(1, lim, xt ? E + 1 : 0);
  endfunction

  function automatic int exp_hold(input int sel, input int mode, input bit por);
    return 1 + (por ? R : 0) + (is_xtal(sel, mode) ? E + 1 : 1);
  endfunction

  // Raise an event for two edges, drop it, then record the edge index of each output change.
  task automatic measure(input bit use_por, output int nr, output int nh, output int ne);
    nr = -1; nh = -1; ne = -1;
    @(negedge clk);
    if (use_por) por_i = 1'b1; else brownout_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    por_i = 1'b0; brownout_i = 1'b0;
    for (int k = 1; k <= 120; k++) begin
      @(posedge clk); #1;
      if (nh < 0 && !clk_hold_o) nh = k;
      if (nr < 0 && !sys_rst_o)  nr = k;
      if (ne < 0 && exec_en_o)   ne = k;
      if (nr >= 0 && nh >= 0 && ne >= 0) break;
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  initial begin
    int nr, nh, ne, ex;
    // R12: hardware reset state
    #7;
    check(sys_rst_o && clk_hold_o && !exec_en_o && !bor_flag_o, "R12 reset state",
          {sys_rst_o, clk_hold_o, exec_en_o, bor_flag_o}, 4'b1100);
    @(negedge clk); rst_n = 1'b1;
    nr = -1;
    for (int k = 1; k <= 60; k++) begin
      @(posedge clk); #1;
      if (nr < 0 && !sys_rst_o) nr = k;
    end
    ex = exp_rel(0, 0, 3, 1'b1);
    check(nr == ex, "R12 release after rst_n with regulator delay", nr, ex);

    // R3 R4 R5 R6 R8 R9: sweep every source code, mode and period
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 4; m++)
        for (int p = 0; p < 16; p++) begin
          bit usep;
          usep = ((s + m + p) % 5) == 0;
          @(negedge clk);
          osc_sel_i = 3'(s); pri_mode_i = 2'(m); pwrt_period_i = 4'(p);
          measure(usep, nr, nh, ne);
          ex = exp_rel(s, m, p, usep);
          check(nr == ex, "R3/R4/R5/R6 release edge", nr, ex);
          ex = exp_hold(s, m, usep);
          check(nh == ex, "R8 clock hold edge", nh, ex);
          check(ne == nr, "R9 exec enable with release", ne, nr);
        end

    // R11: stays released
    edges(30);
    check(!sys_rst_o && exec_en_o, "R11 persists", sys_rst_o, 0);
    // R1: brown-out while running
    @(negedge clk); status_clr_i = 1'b1; @(negedge clk); status_clr_i = 1'b0;
    brownout_i = 1'b1;
    @(posedge clk); #1;
    check(sys_rst_o && clk_hold_o && !exec_en_o && bor_flag_o, "R1 brown-out in run",
          {sys_rst_o, clk_hold_o, exec_en_o, bor_flag_o}, 4'b1101);
    @(negedge clk); brownout_i = 1'b0;

    // R10: clear, clear with brown-out, power-on does not set
    @(negedge clk); status_clr_i = 1'b1;
    @(posedge clk); #1;
    check(!bor_flag_o, "R10 clear", bor_flag_o, 0);
    @(negedge clk); brownout_i = 1'b1;
    @(posedge clk); #1;
    check(bor_flag_o, "R10 brown-out beats clear", bor_flag_o, 1);
    @(negedge clk); brownout_i = 1'b0;
    @(posedge clk); #1;
    check(!bor_flag_o, "R10 clear after", bor_flag_o, 0);
    @(negedge clk); status_clr_i = 1'b0;
    osc_sel_i = 3'd0; pri_mode_i = 2'd0; pwrt_period_i = 4'd2;
    measure(1'b1, nr, nh, ne);
    check(!bor_flag_o, "R10 power-on leaves flag clear", bor_flag_o, 0);
    edges(3);
    check(!bor_flag_o, "R10 flag holds clear", bor_flag_o, 0);

    // R7: PLL lock wait
    @(negedge clk); osc_sel_i = 3'd1; pll_locked_i = 1'b0;
    brownout_i = 1'b1; @(negedge clk); brownout_i = 1'b0;
    edges(30);
    check(sys_rst_o && clk_hold_o, "R7 held without lock", {sys_rst_o, clk_hold_o}, 2'b11);
    @(negedge clk); pll_locked_i = 1'b1;
    @(posedge clk); #1;
    check(!sys_rst_o && !clk_hold_o, "R7 release on lock", {sys_rst_o, clk_hold_o}, 2'b00);
    @(negedge clk); osc_sel_i = 3'd0; pll_locked_i = 1'b0;
    measure(1'b0, nr, nh, ne);
    ex = exp_rel(0, 0, 2, 1'b0);
    check(nr == ex, "R7 lock ignored without PLL", nr, ex);
    @(negedge clk); pll_locked_i = 1'b1;

    // R6: no oscillator pulses keeps hold
    @(negedge clk); osc_sel_i = 3'd2; pri_mode_i = 2'd1; osc_tick_i = 1'b0;
    brownout_i = 1'b1; @(negedge clk); brownout_i = 1'b0;
    edges(40);
    check(sys_rst_o && clk_hold_o, "R6 held without pulses", {sys_rst_o, clk_hold_o}, 2'b11);
    @(negedge clk); osc_tick_i = 1'b1;
    edges(E);
    check(sys_rst_o, "R6 held until count", sys_rst_o, 1);
    @(posedge clk); #1;
    check(!sys_rst_o, "R6 release after count", sys_rst_o, 0);

    // R2: restart inside the wait and inside the regulator delay
    @(negedge clk); osc_sel_i = 3'd0; pri_mode_i = 2'd0; pwrt_period_i = 4'd10;
    brownout_i = 1'b1; @(negedge clk); brownout_i = 1'b0;
    edges(4);
    measure(1'b0, nr, nh, ne);
    ex = exp_rel(0, 0, 10, 1'b0);
    check(nr == ex, "R2 restart in wait", nr, ex);
    @(negedge clk); por_i = 1'b1; @(negedge clk); por_i = 1'b0;
    edges(2);
    measure(1'b0, nr, nh, ne);
    ex = exp_rel(0, 0, 10, 1'b1);
    check(nr == ex, "R2 R3 restart keeps regulator delay", nr, ex);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule